// File: doc/BRIEF.md
# SDLC Transmit Idle-Line Controller

This block sequences the transmit side of an SDLC link from the start of a frame to the idle state of the line. It steps through an opening flag, the data field, an optional CRC field, and then either a closing flag or an abort. After that it returns to idle. Every step moves on a bit tick, which is a one-cycle strobe marking the falling transmit-clock edge at a bit-cell boundary. Flag generation, CRC generation and bit stuffing sit outside this block. The block only tells the serializer what to send: a flag request, an abort (all ones) request, or a forced-high line.

When the link runs SDLC with NRZI coding and the mark idle option is set, the block forces the serial line high once idle is reached. It does this on the tick that ends the last bit of the closing flag or abort, whichever path led there. If the line was sending idle flags when mark idle was selected, forcing starts on the tick that ends the flag in progress.

With automatic opening flags enabled, a new frame request releases the forced level and starts an opening flag with no further command. With automatic opening flags disabled, a frame request is ignored while the line is marking. Mark idle has to be cleared first, so that idle flags run and the frame can start.

Top module: `sdlc_idle_line`

## Requirements
- R1: `forceHigh` is 1 only when `cfgSdlc`, `cfgNrzi` and `cfgMarkIdle` are all 1, the phase is IDLE and the line is marking. Otherwise it is 0.
- R2: Each path into idle ends in a forced-high line, provided R1's configuration holds. The paths are: data then CRC then closing flag; data then closing flag; data then underrun abort; data then commanded abort.
- R3: The `phase` output uses the codes IDLE=0, OPEN_FLAG=1, DATA=2, CRC=3, CLOSE_FLAG=4 and ABORT=5. Phase lengths are set by parameters: an opening or closing flag lasts FLAG_BITS ticks (default 8), CRC lasts CRC_BITS ticks (default 16) and an abort lasts ABORT_BITS ticks (default 7).
- R4: `forceHigh` stays 0 through the whole closing flag. It rises on the tick that ends the flag's last bit, which is the same tick on which the phase becomes IDLE.
- R5: Clearing `cfgMarkIdle` drops `forceHigh` in the same cycle, with no tick needed. Idle flags (`flagReq`=1) begin at the next tick.
- R6: If `cfgMarkIdle` is set while idle flags are running, the current flag completes with `forceHigh`=0. `forceHigh` rises on the tick that ends that flag.
- R7: With `cfgAutoOpen`=1, a `frameStart` on a tick while marking moves the phase to OPEN_FLAG. `forceHigh` drops to 0 and `flagReq` rises to 1.
- R8: With `cfgAutoOpen`=0, a `frameStart` while marking is ignored: the phase stays IDLE and `forceHigh` stays 1. If idle flags are running, `frameStart` starts OPEN_FLAG.
- R9: In DATA, on a tick, `underrun` or `abortCmd` leads to ABORT, and this takes priority over `endOfData`. `endOfData` alone leads to CRC when `cfgCrcEn`=1 and to CLOSE_FLAG otherwise.
- R10: Frame events and phase changes act only on a cycle with `bitTick`=1. Events held high without a tick have no effect.
- R11: `flagReq` is 1 in OPEN_FLAG, in CLOSE_FLAG and in idle while flags run. `abortReq` is 1 only in ABORT.
- R12: Out of reset, the phase is IDLE and the line is marking, with `flagReq`=0 and `abortReq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Strobe on the falling transmit-clock edge at a bit boundary |
| cfgSdlc | input | 1 | SDLC mode selected |
| cfgNrzi | input | 1 | NRZI line coding selected |
| cfgMarkIdle | input | 1 | Idle as mark (1) or idle as flags (0) |
| cfgAutoOpen | input | 1 | Automatic opening flag on a new frame |
| cfgCrcEn | input | 1 | Send a CRC field after data |
| frameStart | input | 1 | New frame requested |
| endOfData | input | 1 | Last data bit sent |
| underrun | input | 1 | Transmit underrun in data |
| abortCmd | input | 1 | Abort commanded |
| forceHigh | output | 1 | Serial line forced high |
| flagReq | output | 1 | Serializer should send flag bits |
| abortReq | output | 1 | Serializer should send abort ones |
| phase | output | 3 | Current phase code |

## Verification
The embedded assertions check several rules on every cycle. Phases change only on ticks. DATA is entered only from OPEN_FLAG, and IDLE only from CLOSE_FLAG or ABORT. The bit counter stays inside its phase limit. A forced line never coincides with a flag or abort request, and the line is forced on the very tick that enters idle. The directed scenarios are needed for the rest. They measure exact phase lengths, walk all four frame endings, and show that forcing is withheld under NRZ coding. They also cover the idle-flag-to-mark handover at a flag boundary, the immediate release when mark idle clears, and the different handling of frame requests with and without automatic opening flags.

// File: rtl/sdlc_idle_pkg.sv
package sdlc_idle_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPEN  = 3'd1,
    PH_DATA  = 3'd2,
    PH_CRC   = 3'd3,
    PH_CLOSE = 3'd4,
    PH_ABORT = 3'd5
  } phase_e;

  // control-to-datapath strobes, valid for one clock
  typedef struct packed {
    logic tick;
    logic cntClr;
    logic markSet;
    logic markClr;
  } strobe_t;

endpackage

// File: rtl/sdlc_idle_fsm.sv
module sdlc_idle_fsm
  import sdlc_idle_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitTick,
  input  logic    cfgMarkIdle,
  input  logic    cfgAutoOpen,
  input  logic    cfgCrcEn,
  input  logic    frameStart,
  input  logic    endOfData,
  input  logic    underrun,
  input  logic    abortCmd,
  input  logic    cntLast,
  input  logic    marking,
  output phase_e  phase,
  output strobe_t stb
);

  phase_e phaseNext;

  always_comb begin
    phaseNext   = phase;
    stb         = '0;
    stb.tick    = bitTick;
    if (bitTick) begin
      unique case (phase)
        PH_IDLE: begin
          if (frameStart && (!marking || cfgAutoOpen)) begin
            phaseNext   = PH_OPEN;
            stb.cntClr  = 1'b1;
            stb.markClr = 1'b1;
          end else if (marking) begin
            stb.cntClr = 1'b1;
            if (!cfgMarkIdle) stb.markClr = 1'b1;
          end else if (cntLast) begin
            stb.cntClr = 1'b1;
            if (cfgMarkIdle) stb.markSet = 1'b1;
          end
        end
        PH_OPEN: begin
          if (cntLast) begin
            phaseNext  = PH_DATA;
            stb.cntClr = 1'b1;
          end
        end
        PH_DATA: begin
          stb.cntClr = 1'b1;
          if (underrun || abortCmd)  phaseNext = PH_ABORT;
          else if (endOfData)        phaseNext = cfgCrcEn ? PH_CRC : PH_CLOSE;
        end
        PH_CRC: begin
          if (cntLast) begin
            phaseNext  = PH_CLOSE;
            stb.cntClr = 1'b1;
          end
        end
        PH_CLOSE, PH_ABORT: begin
          if (cntLast) begin
            phaseNext   = PH_IDLE;
            stb.cntClr  = 1'b1;
            stb.markSet = cfgMarkIdle;
            stb.markClr = !cfgMarkIdle;
          end
        end
        default: begin
          phaseNext  = PH_IDLE;
          stb.cntClr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // R10: phase only moves on a tick
  a_r10_move_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase)) |-> $past(bitTick));

  // R3: data is reached only through the opening flag
  a_r3_data_from_open: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && $past(phase) != PH_DATA) |-> $past(phase) == PH_OPEN);

  // R2: idle is re-entered only from a closing flag or an abort
  a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && $past(phase) != PH_IDLE)
      |-> ($past(phase) == PH_CLOSE || $past(phase) == PH_ABORT));

endmodule

// File: rtl/sdlc_idle_dp.sv
module sdlc_idle_dp
  import sdlc_idle_pkg::*;
#(
  parameter int FLAG_BITS  = 8,
  parameter int CRC_BITS   = 16,
  parameter int ABORT_BITS = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  phase_e  phase,
  input  strobe_t stb,
  input  logic    cfgSdlc,
  input  logic    cfgNrzi,
  input  logic    cfgMarkIdle,
  output logic    cntLast,
  output logic    marking,
  output logic    forceHigh,
  output logic    flagReq,
  output logic    abortReq
);

  localparam int MAX_A    = (FLAG_BITS > CRC_BITS) ? FLAG_BITS : CRC_BITS;
  localparam int MAX_BITS = (MAX_A > ABORT_BITS) ? MAX_A : ABORT_BITS;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             hasLimit;
  logic             forceCfg;

  always_comb begin
    hasLimit = 1'b1;
    unique case (phase)
      PH_CRC:   lastIdx = CNT_W'(CRC_BITS - 1);
      PH_ABORT: lastIdx = CNT_W'(ABORT_BITS - 1);
      PH_DATA: begin
        lastIdx  = '0;
        hasLimit = 1'b0;
      end
      default:  lastIdx = CNT_W'(FLAG_BITS - 1);
    endcase
  end

  assign cntLast = hasLimit && (bitCnt == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      marking <= 1'b1;
    end else if (stb.tick) begin
      if (stb.cntClr) bitCnt <= '0;
      else            bitCnt <= bitCnt + 1'b1;
      if (stb.markSet)      marking <= 1'b1;
      else if (stb.markClr) marking <= 1'b0;
    end
  end

  assign forceCfg  = cfgSdlc && cfgNrzi && cfgMarkIdle;
  assign forceHigh = forceCfg && marking && (phase == PH_IDLE);
  assign flagReq   = (phase == PH_OPEN) || (phase == PH_CLOSE)
                   || ((phase == PH_IDLE) && !marking);
  assign abortReq  = (phase == PH_ABORT);

  // R3: counter never passes the limit of a bounded phase
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    hasLimit |-> bitCnt <= lastIdx);

  // R11: a forced line never overlaps a flag or abort request
  a_r11_force_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    forceHigh |-> (!flagReq && !abortReq));

  // R2/R4: entering idle with forcing configured forces the line at once
  a_r4_force_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) != PH_IDLE && phase == PH_IDLE && $past(cfgMarkIdle)
      && forceCfg) |-> forceHigh);

endmodule

// File: rtl/sdlc_idle_line.sv
module sdlc_idle_line
  import sdlc_idle_pkg::*;
#(
  parameter int FLAG_BITS  = 8,
  parameter int CRC_BITS   = 16,
  parameter int ABORT_BITS = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       cfgSdlc,
  input  logic       cfgNrzi,
  input  logic       cfgMarkIdle,
  input  logic       cfgAutoOpen,
  input  logic       cfgCrcEn,
  input  logic       frameStart,
  input  logic       endOfData,
  input  logic       underrun,
  input  logic       abortCmd,
  output logic       forceHigh,
  output logic       flagReq,
  output logic       abortReq,
  output logic [2:0] phase
);

  phase_e  phaseQ;
  strobe_t stb;
  logic    cntLast;
  logic    marking;

  sdlc_idle_fsm uFsm (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .cfgMarkIdle(cfgMarkIdle), .cfgAutoOpen(cfgAutoOpen), .cfgCrcEn(cfgCrcEn),
    .frameStart(frameStart), .endOfData(endOfData), .underrun(underrun),
    .abortCmd(abortCmd), .cntLast(cntLast), .marking(marking),
    .phase(phaseQ), .stb(stb)
  );

  sdlc_idle_dp #(
    .FLAG_BITS(FLAG_BITS), .CRC_BITS(CRC_BITS), .ABORT_BITS(ABORT_BITS)
  ) uDp (
    .clk(clk), .rstN(rstN), .phase(phaseQ), .stb(stb),
    .cfgSdlc(cfgSdlc), .cfgNrzi(cfgNrzi), .cfgMarkIdle(cfgMarkIdle),
    .cntLast(cntLast), .marking(marking), .forceHigh(forceHigh),
    .flagReq(flagReq), .abortReq(abortReq)
  );

  assign phase = phaseQ;

endmodule

// File: tb/sdlc_idle_line_test.sv
module sdlc_idle_line_test;

  localparam int P_IDLE = 0, P_OPEN = 1, P_DATA = 2, P_CRC = 3, P_CLOSE = 4, P_ABORT = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic cfgSdlc = 1'b1, cfgNrzi = 1'b1, cfgMarkIdle = 1'b1, cfgAutoOpen = 1'b1, cfgCrcEn = 1'b1;
  logic frameStart = 1'b0, endOfData = 1'b0, underrun = 1'b0, abortCmd = 1'b0;
  logic forceHigh, flagReq, abortReq;
  logic [2:0] phase;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sdlc_idle_line uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .cfgSdlc(cfgSdlc), .cfgNrzi(cfgNrzi), .cfgMarkIdle(cfgMarkIdle),
    .cfgAutoOpen(cfgAutoOpen), .cfgCrcEn(cfgCrcEn),
    .frameStart(frameStart), .endOfData(endOfData), .underrun(underrun),
    .abortCmd(abortCmd), .forceHigh(forceHigh), .flagReq(flagReq),
    .abortReq(abortReq), .phase(phase)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one bit tick; outputs settle by the following negedge
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
      frameStart = 1'b0; endOfData = 1'b0; underrun = 1'b0; abortCmd = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // starts a frame from a marking idle line and runs to DATA
  task automatic openFrame(input string tag);
    frameStart = 1'b1;
    tick();
    chk({tag, " R7 open phase"}, phase, P_OPEN);
    chk({tag, " R7 released"}, forceHigh, 0);
    chk({tag, " R11 flagReq open"}, flagReq, 1);
    tick(7);
    chk({tag, " R3 open still"}, phase, P_OPEN);
    tick();
    chk({tag, " R3 data"}, phase, P_DATA);
    tick(3);
  endtask

  task automatic closeFlag(input string tag);
    chk({tag, " R3 close"}, phase, P_CLOSE);
    tick(7);
    chk({tag, " R4 close last bit"}, phase, P_CLOSE);
    chk({tag, " R4 not yet forced"}, forceHigh, 0);
    tick();
    chk({tag, " R2 idle"}, phase, P_IDLE);
    chk({tag, " R2 forced"}, forceHigh, 1);
  endtask

  task automatic t_reset();
    doReset();
    chk("R12 phase", phase, P_IDLE);
    chk("R12 flagReq", flagReq, 0);
    chk("R12 abortReq", abortReq, 0);
    chk("R1 forced after reset", forceHigh, 1);
  endtask

  task automatic t_crcPath();
    cfgCrcEn = 1'b1;
    openFrame("crc");
    endOfData = 1'b1;
    tick();
    chk("R9 crc", phase, P_CRC);
    tick(15);
    chk("R3 crc length", phase, P_CRC);
    tick();
    closeFlag("crc");
  endtask

  task automatic t_flagPath();
    cfgCrcEn = 1'b0;
    openFrame("flag");
    endOfData = 1'b1;
    tick();
    closeFlag("flag");
    cfgCrcEn = 1'b1;
  endtask

  task automatic t_abort(input bit useUnderrun);
    openFrame("abort");
    if (useUnderrun) underrun = 1'b1; else abortCmd = 1'b1;
    endOfData = 1'b1;
    tick();
    chk("R9 abort priority", phase, P_ABORT);
    chk("R11 abortReq", abortReq, 1);
    tick(6);
    chk("R3 abort length", phase, P_ABORT);
    tick();
    chk("R2 abort idle", phase, P_IDLE);
    chk("R2 abort forced", forceHigh, 1);
  endtask

  task automatic t_clearAndRemark();
    cfgMarkIdle = 1'b0;
    #1;
    chk("R5 immediate release", forceHigh, 0);
    chk("R5 no flag before tick", flagReq, 0);
    @(negedge clk);
    tick();
    chk("R5 idle flags", flagReq, 1);
    tick(3);
    cfgMarkIdle = 1'b1;
    tick(4);
    chk("R6 flag completes", forceHigh, 0);
    chk("R6 flag still", flagReq, 1);
    tick();
    chk("R6 forced at boundary", forceHigh, 1);
  endtask

  task automatic t_noAuto();
    cfgAutoOpen = 1'b0;
    frameStart = 1'b1;
    tick();
    chk("R8 ignored phase", phase, P_IDLE);
    chk("R8 still forced", forceHigh, 1);
    cfgMarkIdle = 1'b0;
    tick();
    frameStart = 1'b1;
    tick();
    chk("R8 start from flags", phase, P_OPEN);
    cfgMarkIdle = 1'b1;
    tick(8);
    endOfData = 1'b1;
    cfgCrcEn = 1'b0;
    tick();
    tick(8);
    chk("R2 noauto idle", phase, P_IDLE);
    cfgAutoOpen = 1'b1;
    cfgCrcEn = 1'b1;
  endtask

  task automatic t_noTick();
    frameStart = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 no tick no move", phase, P_IDLE);
    frameStart = 1'b0;
  endtask

  task automatic t_nrz();
    cfgNrzi = 1'b0;
    #1;
    chk("R1 nrz not forced", forceHigh, 0);
    chk("R1 nrz marking", flagReq, 0);
    @(negedge clk);
    cfgNrzi = 1'b1;
    #1;
    chk("R1 nrzi forced", forceHigh, 1);
    cfgSdlc = 1'b0;
    #1;
    chk("R1 non-sdlc not forced", forceHigh, 0);
    cfgSdlc = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_noTick();
    t_crcPath();
    t_flagPath();
    t_abort(1'b1);
    t_abort(1'b0);
    t_clearAndRemark();
    t_noAuto();
    t_nrz();
    finishRun();
  end

endmodule